// File: doc/BRIEF.md
# Bit-Serial Modular Squarer

This block computes y = x² mod n for a wide operand. It is used as the encryption step of a quadratic-residue public key scheme whose additive constant is zero. The modulus n is fixed when the block is built, as a parameter. The operand x is applied in parallel and must be held steady from the start pulse until done. The block contains a general modular multiplier, and both of its operands are wired to x. A shift register supplies the multiplier bits, most significant first. A bit multiplier gates x into the partial product. One adder does three jobs in turn: it accumulates partial products, it subtracts the modulus by adding its two's complement, and it settles the carries it has saved.

The adder is split into 8-bit ripple segments. The carry out of each segment is stored in a flip-flop and goes into the next segment on the following cycle. The sum is doubled only once every saved carry has been folded back into it. A reduction is decided only when no carries are pending. This makes the cycle count data dependent. The result is fully reduced when done is pulsed.

Top module: `modsq_serial`

## Requirements
- R1: When done pulses, y equals (x·x) mod n for any W-bit x, including values of x at or above n.
- R2: done is high for exactly one cycle per accepted start, and is low in the cycle after that.
- R3: y keeps its value from the done pulse until the next accepted start, even if x changes while the block is idle.
- R4: A start that arrives while a squaring is in progress is ignored. The running operation finishes at the same cycle it would have finished without that start.
- R5: done follows the accepted start within W·(5 + 3·K) cycles, where K = ceil((W+2)/SEG) is the number of adder segments.
- R6: While reset is asserted and after it is released, done is low and y is zero.
- R7: When done is high, no saved carry is pending and the internal sum is below n.
- R8: The sum is only ever doubled when all saved segment carries are zero.
- R9: The step counter never exceeds W, and it advances by at most one during a cycle in which a start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a squaring when the block is idle |
| x | input | W | Operand; must be held steady while busy |
| done | output | 1 | One-cycle pulse when y is valid |
| y | output | W | x² mod n, held until the next start |

## Verification
The start pulse is driven at a falling edge and taken at the next rising edge. From that edge the bench counts falling edges until done is seen. The product, the range of y and the latency bound of R5 are all read at the falling edge where done is first high. The one-cycle pulse of R2 is checked at the falling edge that follows. For R4, the latency of a solo run is recorded first, and the same operand is then restarted with an extra start in the middle; done must come at the identical count. For R3, y is sampled over thirty idle cycles after done while x is changed.

// File: rtl/modsq_pkg.sv
package modsq_pkg;
   typedef enum logic [1:0] {M_IDLE, M_BUSY, M_FIN} main_st_t;
   typedef enum logic [1:0] {A_SHIFT, A_ADD, A_SETTLE} arith_st_t;
   typedef enum logic [2:0] {OP_HOLD, OP_LOAD, OP_SHIFT, OP_ADDX, OP_ADDN, OP_PROP} op_t;
endpackage

// File: rtl/modsq_seg_adder.sv
module modsq_seg_adder #(
   parameter int SEG  = 8,
   parameter int NSEG = 4
) (
   input  logic [SEG*NSEG-1:0] a,
   input  logic [SEG*NSEG-1:0] b,
   input  logic [NSEG-2:0]     cin,
   output logic [SEG*NSEG-1:0] sum,
   output logic [NSEG-2:0]     cout
);
   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      logic ci;
      if (i == 0) begin : g_lo
         assign ci = 1'b0;
      end else begin : g_hi
         assign ci = cin[i-1];
      end
      if (i < NSEG-1) begin : g_mid
         logic [SEG:0] t;
         assign t = {1'b0, a[i*SEG +: SEG]} + {1'b0, b[i*SEG +: SEG]} + {{SEG{1'b0}}, ci};
         assign sum[i*SEG +: SEG] = t[SEG-1:0];
         assign cout[i] = t[SEG];
      end else begin : g_top
         // top segment wraps modulo 2^(SEG*NSEG)
         assign sum[i*SEG +: SEG] = a[i*SEG +: SEG] + b[i*SEG +: SEG] + {{(SEG-1){1'b0}}, ci};
      end
   end
endmodule

// File: rtl/modsq_ctrl.sv
module modsq_ctrl
   import modsq_pkg::*;
#(
   parameter int W = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic carry_zero,
   input  logic ge_mod,
   output op_t  op,
   output logic shift_en,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(W + 1);

   main_st_t  main_q, main_n;
   arith_st_t arith_q, arith_n;
   logic [CW-1:0] cnt_q;
   logic cnt_en, cnt_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         main_q  <= M_IDLE;
         arith_q <= A_SHIFT;
         cnt_q   <= '0;
      end else begin
         main_q  <= main_n;
         arith_q <= arith_n;
         if (cnt_clr)     cnt_q <= '0;
         else if (cnt_en) cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      main_n   = main_q;
      arith_n  = arith_q;
      op       = OP_HOLD;
      shift_en = 1'b0;
      cnt_en   = 1'b0;
      cnt_clr  = 1'b0;
      case (main_q)
         M_IDLE: if (start) begin
            op      = OP_LOAD;
            main_n  = M_BUSY;
            arith_n = A_SHIFT;
            cnt_clr = 1'b1;
         end
         M_BUSY: case (arith_q)
            A_SHIFT: begin
               op      = OP_SHIFT;
               arith_n = A_ADD;
            end
            A_ADD: begin
               op       = OP_ADDX;
               shift_en = 1'b1;
               cnt_en   = 1'b1;
               arith_n  = A_SETTLE;
            end
            default: begin
               if (!carry_zero)  op = OP_PROP;
               else if (ge_mod)  op = OP_ADDN;
               else begin
                  arith_n = A_SHIFT;
                  if (cnt_q == CW'(W)) main_n = M_FIN;
               end
            end
         endcase
         M_FIN:   main_n = M_IDLE;
         default: main_n = M_IDLE;
      endcase
   end

   assign busy = (main_q != M_IDLE);
   assign done = (main_q == M_FIN);

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(W));
   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (main_q == M_BUSY && start && arith_q != A_ADD) |=> $stable(cnt_q));
endmodule

// File: rtl/modsq_serial.sv
module modsq_serial
   import modsq_pkg::*;
#(
   parameter int          W       = 512,
   parameter int          SEG     = 8,
   parameter logic [W-1:0] MODULUS = {1'b1, {(W-2){1'b0}}, 1'b1}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] x,
   output logic         done,
   output logic [W-1:0] y
);
   localparam int SW   = W + 2;
   localparam int NSEG = (SW + SEG - 1) / SEG;
   localparam int PW   = NSEG * SEG;
   localparam int NC   = NSEG - 1;
   localparam logic [PW-1:0] MOD_EXT = PW'(MODULUS);
   localparam logic [PW-1:0] NEG_EXT = PW'(0) - MOD_EXT;

   if (SEG < 2) begin : g_bad_seg
      $error("segment width must be at least 2");
   end
   if (W < 4) begin : g_bad_w
      $error("operand width must be at least 4");
   end
   if (MODULUS < 2) begin : g_bad_mod
      $error("modulus must be at least 2");
   end

   op_t op;
   logic shift_en, busy;
   logic [PW-1:0] s_q, b_in, sum;
   logic [NC-1:0] c_q, cout;
   logic [W-1:0]  mreg_q;

   modsq_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .carry_zero(c_q == '0), .ge_mod(s_q >= MOD_EXT),
      .op(op), .shift_en(shift_en), .busy(busy), .done(done)
   );

   // bit multiplier and operand mux
   always_comb begin
      case (op)
         OP_ADDX: b_in = mreg_q[W-1] ? PW'(x) : '0;
         OP_ADDN: b_in = NEG_EXT;
         default: b_in = '0;
      endcase
   end

   modsq_seg_adder #(.SEG(SEG), .NSEG(NSEG)) u_add (
      .a(s_q), .b(b_in), .cin(c_q), .sum(sum), .cout(cout)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q    <= '0;
         c_q    <= '0;
         mreg_q <= '0;
      end else begin
         case (op)
            OP_LOAD: begin
               s_q <= '0;
               c_q <= '0;
            end
            OP_SHIFT: s_q <= {s_q[PW-2:0], 1'b0};
            OP_ADDX, OP_ADDN, OP_PROP: begin
               s_q <= sum;
               c_q <= cout;
            end
            default: ;
         endcase
         if (op == OP_LOAD)  mreg_q <= x;
         else if (shift_en)  mreg_q <= {mreg_q[W-2:0], 1'b0};
      end
   end

   assign y = s_q[W-1:0];

   // R8
   shift_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_SHIFT |-> c_q == '0);
   // R7
   done_reduced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (c_q == '0 && s_q < MOD_EXT));
   // R3
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(y));
endmodule

// File: tb/tb_modsq_serial.sv
module tb_modsq_serial;
   localparam int W = 16;
   localparam int SEG = 8;
   localparam int K = (W + 2 + SEG - 1) / SEG;
   localparam int LIMIT = W * (5 + 3 * K);
   localparam logic [W-1:0] NMOD = 16'hFFF1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [W-1:0] x = '0;
   logic done;
   logic [W-1:0] y;
   int checks = 0;
   int fails = 0;

   modsq_serial #(.W(W), .SEG(SEG), .MODULUS(NMOD)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .x(x), .done(done), .y(y)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] sq_ref(input logic [W-1:0] v);
      longint unsigned p;
      p = longint'(v) * longint'(v);
      return W'(p % longint'(NMOD));
   endfunction

   task automatic run_op(input logic [W-1:0] xv, input int extra_at,
                         output int lat, output bit seen);
      @(negedge clk);
      x = xv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < LIMIT + 20) begin
         start = (lat == extra_at);
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      seen = done;
   endtask

   task automatic t_product(input logic [W-1:0] xv);
      int lat;
      bit seen;
      logic [W-1:0] e;
      e = sq_ref(xv);
      run_op(xv, -1, lat, seen);
      check(seen, "R2 done seen", longint'(seen), 1);
      // R1 R8 R9: wrong carry settling or step count breaks the product
      check(y == e, "R1 R8 R9 product", longint'(y), longint'(e));
      check(y < NMOD, "R7 range", longint'(y), longint'(NMOD) - 1);
      check(lat <= LIMIT, "R5 latency", lat, LIMIT);
      @(negedge clk);
      check(!done, "R2 pulse width", longint'(done), 0);
   endtask

   task automatic t_hold();
      int lat;
      bit seen;
      logic [W-1:0] r;
      run_op(16'h3A5C, -1, lat, seen);
      r = y;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         x = W'(i * 977);
         if (y != r) begin
            check(1'b0, "R3 hold", longint'(y), longint'(r));
            break;
         end
      end
      check(y == sq_ref(16'h3A5C), "R3 held value", longint'(y), longint'(sq_ref(16'h3A5C)));
   endtask

   task automatic t_busy_start();
      int l0, l1;
      bit s0, s1;
      run_op(16'hC3B7, -1, l0, s0);
      @(negedge clk);
      run_op(16'hC3B7, 6, l1, s1);
      check(s1 && l1 == l0, "R4 restart ignored latency", l1, l0);
      check(y == sq_ref(16'hC3B7), "R4 result", longint'(y), longint'(sq_ref(16'hC3B7)));
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [W-1:0] lcg;
      repeat (3) @(negedge clk);
      // R6
      check(!done && y == '0, "R6 during reset", longint'(y), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && y == '0, "R6 after reset", longint'(y), 0);

      t_product(16'h0000);
      t_product(16'h0001);
      t_product(16'h0002);
      t_product(NMOD - 16'h1);
      t_product(NMOD);
      t_product(16'hFFFF);
      t_product(16'h0100);
      t_product(16'h8000);
      t_product(16'h7FFF);
      t_product(16'hABCD);
      t_product(16'h1234);
      lcg = 16'h5EED;
      for (int i = 0; i < 20; i++) begin
         lcg = lcg * 16'd25173 + 16'd13849;
         t_product(lcg);
      end
      t_hold();
      t_busy_start();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule